// File: doc/BRIEF.md
# Command Queue Pointer and Completion Interrupt Registers

This block is the register front end of a host-to-device DMA engine's command queue. Software sees an end pointer, a write pointer, a read pointer, an interrupt enable word, an interrupt status word and a set of general scratch words. All of them sit on a simple 32-bit word bus. A write to the write pointer stands for the completion of every queued command. The read pointer takes on the written value, and a completion event is posted in the status word. That event raises the single level interrupt when it is enabled.

Software can skip the event for one update. It writes a fixed key value to the read pointer address first. The next write-pointer update then moves both pointers and leaves the status word and the interrupt unchanged. A parameter chooses between two address layouts, each with its own enable mask and its own completion bit positions. The data movement itself is not part of this block.

Top module: `cmdq_reg_block`

## Requirements
- R1: After a synchronous reset, every register reads 0, the interrupt output is low and the skip flag is clear. The one exception is the status word, which reads 0xF8000000.
- R2: Writes to the end pointer and the write pointer keep only bits 17:0. Bits 31:18 read as 0.
- R3: A write-pointer write also places the same masked value in the read pointer.
- R4: Writing 0xEE882266 to the read pointer address arms the skip flag. Any write to that address leaves the read pointer value, the status word and the interrupt unchanged.
- R5: A write-pointer write with the skip flag clear sets both completion bits in the status word. These are bits 4 and 5 in layout A and bits 16 and 17 in layout B. With the flag armed, the write clears the flag and leaves the status word unchanged.
- R6: The interrupt output goes high one cycle after a write-pointer write that sets completion bits, when at least one of those bits is also set in the enable word. It then stays high. Without such an enable bit the output stays low.
- R7: A status write that has either completion bit set clears both completion bits and drops the interrupt. The other status bits do not change. A status write with neither completion bit set has no effect.
- R8: Enable writes are ANDed with 0xBFEFF07F in layout A and with 0x017003FF in layout B.
- R9: Layout A places the end pointer, write pointer, read pointer, enable and status at byte addresses 0x14, 0x18, 0x1C, 0x20 and 0x24. Layout B places them at 0x18, 0x1C, 0x20, 0x38 and 0x3C.
- R10: Every other word inside the window, which spans byte addresses 0x00 to 0x3F by default, stores all 32 bits of a write and returns them on a read.
- R11: A read at or above the window end returns 0. A write there changes no register; in particular it does not alias onto a word inside the window.
- R12: Read data appears on `bus_rdata` one clock after the cycle with `bus_rd_en` high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr_en | input | 1 | Word write strobe |
| bus_rd_en | input | 1 | Word read strobe |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Level completion interrupt |

## Verification
A write takes effect on the clock edge that samples it, so the stored value, the status bits and the interrupt are all final one cycle after the write strobe. Read data is due one edge after the read strobe. The driver changes the inputs on falling edges. A monitor takes each expected read word from a queue on the falling edge that follows the read's rising edge. The interrupt is sampled at the falling edge after the edge that wrote it. The skip flag cannot be seen directly, so the bench observes it through the status word and the interrupt on the two write-pointer updates that follow it.

// File: rtl/cmdq_regs_pkg.sv
package cmdq_regs_pkg;

    localparam logic [31:0] PTR_KEEP     = 32'h0003_FFFF;
    localparam logic [31:0] SKIP_KEY     = 32'hEE88_2266;
    localparam logic [31:0] STATUS_INIT  = 32'hF800_0000;

    // Byte offsets and per-layout constants
    typedef struct packed {
        logic [11:0] end_off;
        logic [11:0] wp_off;
        logic [11:0] rp_off;
        logic [11:0] en_off;
        logic [11:0] st_off;
        logic [31:0] en_keep;
        logic [31:0] done_bits;
    } layout_t;

    // One-hot style selects produced by the decoder
    typedef struct packed {
        logic in_win;
        logic end_ptr;
        logic wr_ptr;
        logic rd_ptr;
        logic enable;
        logic status;
        logic scratch;
    } hit_t;

    function automatic layout_t layout_of(input int sel);
        layout_t l;
        if (sel == 0) begin
            l.end_off   = 12'h014;
            l.wp_off    = 12'h018;
            l.rp_off    = 12'h01C;
            l.en_off    = 12'h020;
            l.st_off    = 12'h024;
            l.en_keep   = 32'hBFEF_F07F;
            l.done_bits = 32'h0000_0030;
        end else begin
            l.end_off   = 12'h018;
            l.wp_off    = 12'h01C;
            l.rp_off    = 12'h020;
            l.en_off    = 12'h038;
            l.st_off    = 12'h03C;
            l.en_keep   = 32'h0170_03FF;
            l.done_bits = 32'h0003_0000;
        end
        return l;
    endfunction

    function automatic logic is_named(input layout_t l, input int word);
        return (word == int'(l.end_off) / 4) || (word == int'(l.wp_off) / 4) ||
               (word == int'(l.rp_off) / 4) || (word == int'(l.en_off) / 4) ||
               (word == int'(l.st_off) / 4);
    endfunction

endpackage

// File: rtl/cmdq_addr_decode.sv
module cmdq_addr_decode
    import cmdq_regs_pkg::*;
#(
    parameter int MAP_SEL   = 0,
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 16,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam layout_t LAY = layout_of(MAP_SEL);

    logic [ADDR_W-1:0] word;

    always_comb begin
        word        = addr >> 2;
        idx         = word[IDX_W-1:0];
        hit.in_win  = (word < ADDR_W'(NUM_WORDS));
        hit.end_ptr = hit.in_win && (word == ADDR_W'(LAY.end_off >> 2));
        hit.wr_ptr  = hit.in_win && (word == ADDR_W'(LAY.wp_off >> 2));
        hit.rd_ptr  = hit.in_win && (word == ADDR_W'(LAY.rp_off >> 2));
        hit.enable  = hit.in_win && (word == ADDR_W'(LAY.en_off >> 2));
        hit.status  = hit.in_win && (word == ADDR_W'(LAY.st_off >> 2));
        hit.scratch = hit.in_win && !(hit.end_ptr || hit.wr_ptr || hit.rd_ptr ||
                                      hit.enable || hit.status);
    end
endmodule

// File: rtl/cmdq_ptr_regs.sv
module cmdq_ptr_regs
    import cmdq_regs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  hit_t              hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] end_q,
    output logic [DATA_W-1:0] wp_q,
    output logic [DATA_W-1:0] rp_q,
    output logic              done_evt
);
    logic              skip_q;
    logic [DATA_W-1:0] kept;

    assign kept     = wdata & DATA_W'(PTR_KEEP);
    assign done_evt = wr_en && hit.wr_ptr && !skip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            end_q  <= '0;
            wp_q   <= '0;
            rp_q   <= '0;
            skip_q <= 1'b0;
        end else if (wr_en) begin
            if (hit.end_ptr) begin
                end_q <= kept;
            end
            if (hit.wr_ptr) begin
                wp_q   <= kept;
                rp_q   <= kept;
                skip_q <= 1'b0;
            end
            if (hit.rd_ptr && wdata == DATA_W'(SKIP_KEY)) begin
                skip_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmdq_irq_ctrl.sv
module cmdq_irq_ctrl
    import cmdq_regs_pkg::*;
#(
    parameter int MAP_SEL = 0,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  hit_t              hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done_evt,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] st_q,
    output logic              irq_q
);
    localparam layout_t            LAY  = layout_of(MAP_SEL);
    localparam logic [DATA_W-1:0]  DONE = DATA_W'(LAY.done_bits);

    logic ack;
    assign ack = wr_en && hit.status && |(wdata & DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            st_q  <= DATA_W'(STATUS_INIT);
            irq_q <= 1'b0;
        end else begin
            if (wr_en && hit.enable) begin
                en_q <= wdata & DATA_W'(LAY.en_keep);
            end
            if (done_evt) begin
                st_q <= st_q | DONE;
                if (|(en_q & DONE)) begin
                    irq_q <= 1'b1;
                end
            end else if (ack) begin
                st_q  <= st_q & ~DONE;
                irq_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmdq_scratch.sv
module cmdq_scratch
    import cmdq_regs_pkg::*;
#(
    parameter int MAP_SEL   = 0,
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 16,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  hit_t              hit,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);
    localparam layout_t LAY = layout_of(MAP_SEL);

    logic [DATA_W-1:0] store [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        if (is_named(LAY, i)) begin : g_none
            assign store[i] = '0;
        end else begin : g_flop
            always_ff @(posedge clk) begin
                if (rst) begin
                    store[i] <= '0;
                end else if (wr_en && hit.scratch && idx == IDX_W'(i)) begin
                    store[i] <= wdata;
                end
            end
        end
    end

    assign rd_word = store[idx];
endmodule

// File: rtl/cmdq_reg_block.sv
module cmdq_reg_block
    import cmdq_regs_pkg::*;
#(
    parameter int MAP_SEL   = 0,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    hit_t              hit;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] end_q, wp_q, rp_q, en_q, st_q, scr_word, rd_mux;
    logic              done_evt;

    cmdq_addr_decode #(.MAP_SEL(MAP_SEL), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx)
    );

    cmdq_ptr_regs #(.DATA_W(DATA_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr_en),
        .hit      (hit),
        .wdata    (bus_wdata),
        .end_q    (end_q),
        .wp_q     (wp_q),
        .rp_q     (rp_q),
        .done_evt (done_evt)
    );

    cmdq_irq_ctrl #(.MAP_SEL(MAP_SEL), .DATA_W(DATA_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr_en),
        .hit      (hit),
        .wdata    (bus_wdata),
        .done_evt (done_evt),
        .en_q     (en_q),
        .st_q     (st_q),
        .irq_q    (irq_out)
    );

    cmdq_scratch #(.MAP_SEL(MAP_SEL), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_scr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr_en),
        .hit     (hit),
        .idx     (idx),
        .wdata   (bus_wdata),
        .rd_word (scr_word)
    );

    always_comb begin
        if (!hit.in_win)     rd_mux = '0;
        else if (hit.end_ptr) rd_mux = end_q;
        else if (hit.wr_ptr)  rd_mux = wp_q;
        else if (hit.rd_ptr)  rd_mux = rp_q;
        else if (hit.enable)  rd_mux = en_q;
        else if (hit.status)  rd_mux = st_q;
        else                  rd_mux = scr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd_en) begin
            bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/cmdq_reg_block_chk.sv
module cmdq_reg_block_chk
    import cmdq_regs_pkg::*;
#(
    parameter int MAP_SEL   = 0,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_out
);
    localparam layout_t LAY = layout_of(MAP_SEL);

    logic wp_wr, rp_wr, st_ack, far_rd;
    assign wp_wr  = bus_wr_en && bus_addr == ADDR_W'(LAY.wp_off);
    assign rp_wr  = bus_wr_en && bus_addr == ADDR_W'(LAY.rp_off);
    assign st_ack = bus_wr_en && bus_addr == ADDR_W'(LAY.st_off) &&
                    |(bus_wdata & DATA_W'(LAY.done_bits));
    assign far_rd = bus_rd_en && (bus_addr >= ADDR_W'(NUM_WORDS * 4));

    // R1
    reset_irq_low_chk: assert property (@(posedge clk) $past(rst) |-> !irq_out);

    // R6
    irq_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> $past(wp_wr));

    // R7
    irq_ack_chk: assert property (@(posedge clk) disable iff (rst)
        st_ack |=> !irq_out);

    // R4
    key_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rp_wr |=> $stable(irq_out));

    // R11
    far_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        far_rd |=> bus_rdata == '0);
endmodule

bind cmdq_reg_block cmdq_reg_block_chk #(
    .MAP_SEL(MAP_SEL), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
);

// File: tb/test_cmdq_reg_block.sv
`timescale 1ns/1ps
module test_cmdq_reg_block;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_a = 1'b0, rd_a = 1'b0, wr_b = 1'b0, rd_b = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        irq_a, irq_b;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cmdq_reg_block #(.MAP_SEL(0)) i_cmdq_reg_block (
        .clk(clk), .rst(rst), .bus_wr_en(wr_a), .bus_rd_en(rd_a),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_a), .irq_out(irq_a)
    );

    cmdq_reg_block #(.MAP_SEL(1)) i_cmdq_reg_block_b (
        .clk(clk), .rst(rst), .bus_wr_en(wr_b), .bus_rd_en(rd_b),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_b), .irq_out(irq_b)
    );

    // scoreboard queues
    logic [31:0] exp_q [$];
    string       tag_q [$];
    bit          who_q [$];
    logic        pend_q = 1'b0;
    logic        pend_b = 1'b0;

    always @(posedge clk) begin
        pend_q <= rd_a | rd_b;
        pend_b <= rd_b;
    end

    always @(negedge clk) begin
        if (pend_q && exp_q.size() > 0) begin
            logic [31:0] e;
            logic [31:0] got;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            void'(who_q.pop_front());
            got = pend_b ? rdata_b : rdata_a;
            checks++;
            if (got !== e) begin
                fails++;
                $display("FAIL %s read: got %08h expected %08h", t, got, e);
            end
        end
    end

    task automatic wr(input bit b, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (b) wr_b = 1'b1; else wr_a = 1'b1;
        @(negedge clk);
        wr_a = 1'b0; wr_b = 1'b0;
    endtask

    task automatic rd(input bit b, input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        addr = a;
        exp_q.push_back(e); tag_q.push_back(t); who_q.push_back(b);
        if (b) rd_b = 1'b1; else rd_a = 1'b1;
        @(negedge clk);
        rd_a = 1'b0; rd_b = 1'b0;
    endtask

    task automatic chk_irq(input bit b, input logic e, input string t);
        logic got;
        got = b ? irq_b : irq_a;
        checks++;
        if (got !== e) begin
            fails++;
            $display("FAIL %s irq: got %0b expected %0b", t, got, e);
        end
    endtask

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(0, 12'h024, 32'hF800_0000, "R1");
        rd(0, 12'h014, 32'h0, "R1");
        rd(0, 12'h000, 32'h0, "R1");
        rd(1, 12'h03C, 32'hF800_0000, "R1");
        chk_irq(0, 1'b0, "R1");
        // R2 pointer masking
        wr(0, 12'h014, 32'hFFFF_FFFF);
        rd(0, 12'h014, 32'h0003_FFFF, "R2");
        // R8 enable masks per layout
        wr(0, 12'h020, 32'hFFFF_FFFF);
        rd(0, 12'h020, 32'hBFEF_F07F, "R8");
        wr(1, 12'h038, 32'hFFFF_FFFF);
        rd(1, 12'h038, 32'h0170_03FF, "R8");
        // R3 R5 R6 completion
        wr(0, 12'h018, 32'hFFFF_1234);
        chk_irq(0, 1'b1, "R6");
        rd(0, 12'h018, 32'h0003_1234, "R2");
        rd(0, 12'h01C, 32'h0003_1234, "R3");
        rd(0, 12'h024, 32'hF800_0030, "R5");
        chk_irq(0, 1'b1, "R6 level hold");
        // R7 acknowledge
        wr(0, 12'h024, 32'h0000_0000);
        rd(0, 12'h024, 32'hF800_0030, "R7 no-op");
        chk_irq(0, 1'b1, "R7 no-op");
        wr(0, 12'h024, 32'h0000_0010);
        chk_irq(0, 1'b0, "R7");
        rd(0, 12'h024, 32'hF800_0000, "R7");
        // R4 key and other read-pointer writes
        wr(0, 12'h01C, 32'h1234_5678);
        rd(0, 12'h01C, 32'h0003_1234, "R4 plain");
        rd(0, 12'h024, 32'hF800_0000, "R4 plain");
        wr(0, 12'h01C, 32'hEE88_2266);
        rd(0, 12'h01C, 32'h0003_1234, "R4 key");
        chk_irq(0, 1'b0, "R4 key");
        wr(0, 12'h018, 32'h0000_0055);
        chk_irq(0, 1'b0, "R5 skipped");
        rd(0, 12'h01C, 32'h0000_0055, "R3 skipped");
        rd(0, 12'h024, 32'hF800_0000, "R5 skipped");
        wr(0, 12'h018, 32'h0000_0066);
        chk_irq(0, 1'b1, "R5 one-shot");
        rd(0, 12'h024, 32'hF800_0030, "R5 one-shot");
        wr(0, 12'h024, 32'hFFFF_FFFF);
        chk_irq(0, 1'b0, "R7 all-ones");
        rd(0, 12'h024, 32'hF800_0000, "R7 all-ones");
        // R6 without enable
        wr(0, 12'h020, 32'h0);
        wr(0, 12'h018, 32'h0000_0007);
        chk_irq(0, 1'b0, "R6 disabled");
        rd(0, 12'h024, 32'hF800_0030, "R6 disabled");
        wr(0, 12'h024, 32'h0000_0020);
        rd(0, 12'h024, 32'hF800_0000, "R7 bit5");
        // R10 scratch
        wr(0, 12'h000, 32'hDEAD_BEEF);
        rd(0, 12'h000, 32'hDEAD_BEEF, "R10");
        wr(0, 12'h02C, 32'hA5A5_0F0F);
        rd(0, 12'h02C, 32'hA5A5_0F0F, "R10");
        // R9 layout B
        wr(1, 12'h014, 32'hFFFF_FFFF);
        rd(1, 12'h014, 32'hFFFF_FFFF, "R9 scratch");
        wr(1, 12'h01C, 32'hFFFF_ABCD);
        rd(1, 12'h020, 32'h0003_ABCD, "R9 rp");
        rd(1, 12'h03C, 32'hF803_0000, "R9 status");
        chk_irq(1, 1'b0, "R9 mask");
        // R11 out of window
        wr(0, 12'h100, 32'h0000_0001);
        rd(0, 12'h000, 32'hDEAD_BEEF, "R11 alias");
        rd(0, 12'h100, 32'h0, "R11");
        rd(0, 12'h040, 32'h0, "R11");
        // R12 holding read data
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (rdata_a !== 32'h0) begin
            fails++;
            $display("FAIL R12 hold: got %08h expected %08h", rdata_a, 32'h0);
        end
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule